// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received network frames from a receive FIFO into buffers in host memory. A ring of four-word descriptors lives in host memory and describes those buffers. The engine reads each descriptor and accepts it only when the ownership flag shows the engine owns it. It writes the frame words into the buffer and then writes a closing status word that hands the descriptor back to the host. That status word marks the first and last pieces of each frame and records the frame length.

While it holds a descriptor, the engine reads the following descriptor ahead of time, so the next frame can start without a fetch delay. If the engine meets a descriptor the host still owns, it raises a buffer-unavailable event and suspends without moving its ring position. While suspended, a newly arriving frame makes the engine re-read that descriptor. The engine then either resumes or discards the frame and counts it as missed. A configuration input can disable the discard, and a poll input forces a re-read.

Host memory is a single request/acknowledge port carrying 32-bit words. The FIFO is a valid/ready word stream with an end-of-frame marker.

Top module: `rx_desc_dma`

## Requirements
- R1: While reset is asserted, and while `run` stays low afterwards, there is no memory request and no FIFO pop. `suspended`, both event outputs and `missed_cnt` are 0.
- R2: Each descriptor is four words at consecutive byte addresses. Word 0 holds ownership in bit 31 (1 = engine owns it). Word 1 holds an end-of-ring flag in bit 31 and the buffer size in words in bits 15:0, which must be at least 1. Word 2 holds the buffer byte address. Word 3 holds the next descriptor address. When `run` rises, the engine fetches the descriptor at `ring_base`.
- R3: After it acquires an engine-owned descriptor, the engine fetches the following descriptor without waiting for a frame. The following descriptor is the one at `ring_base` if end-of-ring is set, and the one at word 3 otherwise. The engine then goes idle.
- R4: Frame word i within a descriptor is written to byte address buffer + 4·i. A pending memory request holds its address and direction until it is acknowledged.
- R5: Closing a descriptor writes its word 0 as follows: bit 31 = 0; bit 9 = first piece of the frame; bit 8 = last piece; bits 29:16 = frame length in words when bit 8 is set, otherwise 0. All other bits are 0.
- R6: When a buffer fills before the frame ends, the descriptor is closed without the last flag. The frame continues in the next descriptor with the first flag clear. A frame that exactly fills one buffer gets one descriptor with both flags set.
- R7: `evt_rx_done` pulses once per frame, one cycle after the last descriptor's word 0 write is acknowledged.
- R8: A host-owned descriptor at the point of acquisition causes an `evt_buf_unavail` pulse, sets `suspended`, and keeps the ring position. Later re-reads use that same descriptor address.
- R9: A frame arriving while suspended triggers a re-read. If the descriptor is now engine-owned, `suspended` clears and the frame is received into it.
- R10: With `flush_dis` low, a still host-owned re-read discards the head frame with no memory write and adds 1 to `missed_cnt`. This repeats for each stored frame, and each re-read pulses `evt_buf_unavail`.
- R11: With `flush_dis` high, a still host-owned re-read pulses `evt_buf_unavail` and pops nothing. No further re-read happens until `poll`.
- R12: `poll` while suspended forces a re-read. If the descriptor is engine-owned, reception resumes.
- R13: `missed_cnt` saturates at 2^MISS_W−1 and returns to 0 in the cycle after `missed_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Receive enable |
| poll | input | 1 | Receive poll demand pulse |
| flush_dis | input | 1 | Keep the head frame instead of discarding it when no buffer exists |
| ring_base | input | 32 | Byte address of the first ring descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fifo_valid | input | 1 | FIFO head word present |
| fifo_data | input | 32 | FIFO head word |
| fifo_last | input | 1 | Head word ends its frame |
| fifo_ready | output | 1 | Pop the head word |
| evt_rx_done | output | 1 | Frame-complete event pulse |
| evt_buf_unavail | output | 1 | Buffer-unavailable event pulse |
| suspended | output | 1 | Engine waits on a host-owned descriptor |
| missed_rd | input | 1 | Host read of the missed counter; clears it |
| missed_cnt | output | MISS_W | Frames discarded for lack of a buffer |

## Verification
The bench walks a four-entry ring through three cases: a single-descriptor frame, a frame split across two buffers, and a frame that exactly fills its buffer. If the full-buffer test were wrong, the exact-fit frame would come out as two descriptors, or a split frame would lose its last flag. Wrap-around at the end of the ring is confirmed by counting re-reads of the first descriptor. A design that advanced on suspension would re-read the wrong entry instead. Suspension is then exercised in turn with flushing enabled, with flushing disabled, with a poll, and with a buffer that returns just as a frame arrives. A discard that wrote memory, a flush-disabled engine that popped the FIFO or kept retrying, or a counter that wrapped instead of saturating each shows up as a wrong count.

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int LEN_W  = 14,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              poll,
  input  logic              flush_dis,
  input  logic [31:0]       ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              fifo_valid,
  input  logic [31:0]       fifo_data,
  input  logic              fifo_last,
  output logic              fifo_ready,
  output logic              evt_rx_done,
  output logic              evt_buf_unavail,
  output logic              suspended,
  input  logic              missed_rd,
  output logic [MISS_W-1:0] missed_cnt
);
  localparam int OWN_B = 31, EOR_B = 31, FIRST_B = 9, LAST_B = 8, LEN_LO = 16, SZ_W = 16;
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  typedef enum logic [2:0] {S_STOP, S_FETCH, S_WAIT, S_XFER, S_CLOSE, S_SUSP, S_DROP} st_t;
  typedef enum logic [1:0] {F_CUR, F_SPARE, F_FRAME, F_POLL} why_t;

  st_t st;
  why_t why;
  logic [1:0]       fw;
  logic [31:0]      c_addr, c_buf, c_next, s_addr, s_buf, s_next;
  logic [SZ_W-1:0]  c_size, s_size, idx;
  logic             c_own, c_eor, s_own, s_eor, s_v;
  logic [LEN_W-1:0] flen;
  logic             c_first, c_last, mid, blocked;
  logic [MISS_W-1:0] miss, miss_base;
  logic [31:0]      close_word;

  wire tgt_spare = (why == F_SPARE);
  wire [31:0] c_succ = c_eor ? ring_base : c_next;
  wire [31:0] s_succ = s_eor ? ring_base : s_next;
  wire drop_end = (st == S_DROP) && fifo_valid && fifo_last;

  assign mem_req    = (st == S_FETCH) || (st == S_CLOSE) || (st == S_XFER && fifo_valid);
  assign mem_we     = (st == S_XFER) || (st == S_CLOSE);
  assign fifo_ready = (st == S_XFER && mem_ack) || (st == S_DROP);
  assign missed_cnt = miss;
  assign miss_base  = missed_rd ? '0 : miss;

  always_comb begin
    close_word = '0;
    close_word[FIRST_B] = c_first;
    close_word[LAST_B]  = c_last;
    if (c_last) close_word[LEN_LO +: LEN_W] = flen;
  end

  always_comb begin
    case (st)
      S_FETCH: mem_addr = (tgt_spare ? s_addr : c_addr) + {28'd0, fw, 2'b00};
      S_XFER:  mem_addr = c_buf + {{(30-SZ_W){1'b0}}, idx, 2'b00};
      default: mem_addr = c_addr;
    endcase
    mem_wdata = (st == S_XFER) ? fifo_data : close_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) miss <= '0;
    else if (drop_end && miss_base != MISS_MAX) miss <= miss_base + 1'b1;
    else miss <= miss_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_STOP; why <= F_CUR; fw <= '0;
      c_addr <= '0; c_buf <= '0; c_next <= '0; c_size <= '0; c_own <= 1'b0; c_eor <= 1'b0;
      s_addr <= '0; s_buf <= '0; s_next <= '0; s_size <= '0; s_own <= 1'b0; s_eor <= 1'b0;
      s_v <= 1'b0; idx <= '0; flen <= '0; c_first <= 1'b0; c_last <= 1'b0;
      mid <= 1'b0; blocked <= 1'b0;
      evt_rx_done <= 1'b0; evt_buf_unavail <= 1'b0; suspended <= 1'b0;
    end else begin
      evt_rx_done <= 1'b0;
      evt_buf_unavail <= 1'b0;
      case (st)
        S_STOP: if (run) begin
          c_addr <= ring_base; s_v <= 1'b0; mid <= 1'b0; blocked <= 1'b0;
          why <= F_CUR; fw <= '0; st <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          fw <= fw + 2'd1;
          if (tgt_spare) begin
            case (fw)
              2'd0: s_own <= mem_rdata[OWN_B];
              2'd1: begin s_eor <= mem_rdata[EOR_B]; s_size <= mem_rdata[SZ_W-1:0]; end
              2'd2: s_buf <= mem_rdata;
              default: s_next <= mem_rdata;
            endcase
          end else begin
            case (fw)
              2'd0: c_own <= mem_rdata[OWN_B];
              2'd1: begin c_eor <= mem_rdata[EOR_B]; c_size <= mem_rdata[SZ_W-1:0]; end
              2'd2: c_buf <= mem_rdata;
              default: c_next <= mem_rdata;
            endcase
          end
          if (fw == 2'd3) begin
            if (tgt_spare) begin
              s_v <= 1'b1;
              st <= mid ? S_XFER : S_WAIT;
            end else if (c_own) begin
              suspended <= 1'b0; blocked <= 1'b0; idx <= '0;
              s_addr <= c_eor ? ring_base : mem_rdata;
              why <= F_SPARE; fw <= '0;
            end else begin
              evt_buf_unavail <= 1'b1;
              suspended <= 1'b1;
              if (why == F_FRAME && !flush_dis) st <= S_DROP;
              else begin
                st <= S_SUSP;
                if (why == F_FRAME) blocked <= 1'b1;
              end
            end
          end
        end
        S_WAIT:
          if (!run) st <= S_STOP;
          else if (fifo_valid) begin
            mid <= 1'b1; c_first <= 1'b1; idx <= '0; flen <= '0; st <= S_XFER;
          end
        S_XFER: if (fifo_valid && mem_ack) begin
          idx <= idx + 1'b1;
          flen <= flen + 1'b1;
          if (fifo_last) begin
            c_last <= 1'b1; st <= S_CLOSE;
          end else if (idx + 1'b1 == c_size) begin
            c_last <= 1'b0; st <= S_CLOSE;
          end
        end
        S_CLOSE: if (mem_ack) begin
          evt_rx_done <= c_last;
          mid <= !c_last;
          c_first <= 1'b0;
          idx <= '0;
          fw <= '0;
          s_v <= 1'b0;
          if (s_v && s_own) begin
            c_addr <= s_addr; c_buf <= s_buf; c_size <= s_size; c_eor <= s_eor;
            c_next <= s_next; c_own <= 1'b1;
            s_addr <= s_succ; why <= F_SPARE;
          end else begin
            c_addr <= c_succ; why <= F_CUR;
          end
          st <= S_FETCH;
        end
        S_SUSP:
          if (!run) begin
            st <= S_STOP; suspended <= 1'b0;
          end else if (poll) begin
            blocked <= 1'b0; why <= F_POLL; fw <= '0; st <= S_FETCH;
          end else if (fifo_valid && !blocked) begin
            why <= F_FRAME; fw <= '0; st <= S_FETCH;
          end
        S_DROP: if (drop_end) begin
          mid <= 1'b0; st <= S_SUSP;
        end
        default: st <= S_STOP;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
  AST_SUSP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> evt_buf_unavail); // R8
  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_done |-> $past(mem_ack && mem_we && !mem_wdata[OWN_B] && mem_wdata[LAST_B])); // R7
  AST_MISS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    missed_cnt == MISS_MAX && !missed_rd |=> missed_cnt == MISS_MAX); // R13
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !missed_rd |=> (missed_cnt == $past(missed_cnt) || missed_cnt == $past(missed_cnt) + 1'b1)); // R10
  AST_BLOCKED_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !mem_req && !fifo_ready |=> !fifo_ready || !flush_dis || $past(poll) || $past(fifo_valid)); // R11
endmodule

// File: tb/tb_rx_desc_dma.sv
module tb_rx_desc_dma;
  localparam int MW = 3;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, poll = 1'b0, flush_dis = 1'b0, missed_rd = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic mem_req, mem_we, mem_ack, fifo_valid, fifo_last, fifo_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, fifo_data;
  logic evt_rx_done, evt_buf_unavail, suspended;
  logic [MW-1:0] missed_cnt;

  logic [31:0] mem [0:255];
  logic [31:0] fq_d [0:63];
  logic        fq_l [0:63];
  logic [31:0] fwp = 0, frp = 0;
  logic hw_en = 1'b0;
  logic [31:0] hw_addr = 0, hw_data = 0;
  int rd0 [0:3];
  int dwrites = 0, done_n = 0, ua_n = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  rx_desc_dma #(.LEN_W(14), .MISS_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .flush_dis(flush_dis),
    .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_ready(fifo_ready), .evt_rx_done(evt_rx_done), .evt_buf_unavail(evt_buf_unavail),
    .suspended(suspended), .missed_rd(missed_rd), .missed_cnt(missed_cnt));

  assign mem_rdata  = mem[mem_addr[9:2]];
  assign fifo_valid = (fwp != frp);
  assign fifo_data  = fq_d[frp[5:0]];
  assign fifo_last  = fq_l[frp[5:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
      for (int i = 0; i < 4; i++) rd0[i] <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          if (mem_addr >= 32'h100) dwrites <= dwrites + 1;
        end else if (mem_addr[3:0] == 4'h0 && mem_addr < 32'h40)
          rd0[mem_addr[5:4]] <= rd0[mem_addr[5:4]] + 1;
      end
      if (hw_en) mem[hw_addr[9:2]] <= hw_data;
      if (fifo_valid && fifo_ready) frp <= frp + 1;
      if (evt_rx_done) done_n <= done_n + 1;
      if (evt_buf_unavail) ua_n <= ua_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic push_frame(input int n, input logic [31:0] v);
    for (int i = 0; i < n; i++) begin
      fq_d[fwp[5:0]] = v + i;
      fq_l[fwp[5:0]] = (i == n - 1);
      fwp = fwp + 1;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] w0(input bit f, input bit l, input int len);
    return (l ? (len << 16) : 0) | (32'(f) << 9) | (32'(l) << 8);
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int d0, dw;
    for (int i = 0; i < 64; i++) begin fq_d[i] = 0; fq_l[i] = 1'b0; end
    settle(5);
    chk("R1 req in reset", {31'd0, mem_req}, 0);
    chk("R1 pop in reset", {31'd0, fifo_ready}, 0);
    chk("R1 suspended in reset", {31'd0, suspended}, 0);
    chk("R1 missed in reset", {29'd0, missed_cnt}, 0);
    rst_n = 1'b1;
    settle(10);
    chk("R1 idle without run", {30'd0, mem_req, evt_rx_done | evt_buf_unavail}, 0);
    for (int d = 0; d < 4; d++) begin
      host_wr(d * 16 + 0, 32'h8000_0000);
      host_wr(d * 16 + 4, ((d == 3) ? 32'h8000_0000 : 0) | 4);
      host_wr(d * 16 + 8, 32'h100 + d * 32'h40);
      host_wr(d * 16 + 12, d * 16 + 16);
    end
    run = 1'b1;
    settle(60);
    chk("R2 first fetch at base", rd0[0], 1);
    chk("R3 spare prefetched", rd0[1], 1);
    chk("R3 no fetch beyond spare", rd0[2], 0);
    chk("R3 idle after prefetch", {31'd0, mem_req}, 0);

    push_frame(3, 32'hA000);
    for (int k = 0; k < 2000 && done_n < 1; k++) @(negedge clk);
    settle(40);
    for (int i = 0; i < 3; i++) chk("R4 single buffer data", mem[64 + i], 32'hA000 + i);
    chk("R5 close word single", mem[0], w0(1, 1, 3));
    chk("R7 one done event", done_n, 1);
    chk("R3 prefetch after promote", rd0[2], 1);

    push_frame(6, 32'hB000);
    for (int k = 0; k < 2000 && done_n < 2; k++) @(negedge clk);
    settle(40);
    chk("R6 full buffer close", mem[4], w0(1, 0, 0));
    chk("R6 continuation close", mem[8], w0(0, 1, 6));
    for (int i = 0; i < 4; i++) chk("R4 split data first buf", mem[80 + i], 32'hB000 + i);
    for (int i = 0; i < 2; i++) chk("R4 split data second buf", mem[96 + i], 32'hB004 + i);
    chk("R7 one event for split frame", done_n, 2);

    push_frame(4, 32'hC000);
    for (int k = 0; k < 2000 && ua_n < 1; k++) @(negedge clk);
    settle(20);
    chk("R6 exact fill single descriptor", mem[12], w0(1, 1, 4));
    chk("R8 suspended", {31'd0, suspended}, 1);
    chk("R8 unavail event", ua_n, 1);
    chk("R2 wrap to base", rd0[0], 3);

    d0 = rd0[0]; dw = dwrites;
    push_frame(2, 32'hF000);
    push_frame(2, 32'hF100);
    settle(200);
    chk("R10 missed count", {29'd0, missed_cnt}, 2);
    chk("R10 no data written", dwrites, dw);
    chk("R10 fifo emptied", fwp - frp, 0);
    chk("R8 refetch same entry", rd0[0], d0 + 2);
    chk("R10 event per refetch", ua_n, 3);

    flush_dis = 1'b1;
    push_frame(2, 32'hD000);
    settle(100);
    chk("R11 frame kept", fwp - frp, 2);
    chk("R11 unavail again", ua_n, 4);
    chk("R11 one refetch", rd0[0], d0 + 3);
    settle(200);
    chk("R11 no retry", rd0[0], d0 + 3);
    chk("R11 still suspended", {31'd0, suspended}, 1);

    host_wr(0, 32'h8000_0000);
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    for (int k = 0; k < 2000 && done_n < 4; k++) @(negedge clk);
    settle(40);
    flush_dis = 1'b0;
    chk("R12 resumed frame close", mem[0], w0(1, 1, 2));
    chk("R12 resumed data", mem[64], 32'hD000);
    chk("R12 resumed data 2", mem[65], 32'hD001);
    chk("R8 suspends at next host entry", ua_n, 5);

    host_wr(16, 32'h8000_0000);
    push_frame(1, 32'hE000);
    for (int k = 0; k < 2000 && done_n < 5; k++) @(negedge clk);
    settle(40);
    chk("R9 frame resumes", mem[4], w0(1, 1, 1));
    chk("R9 frame data", mem[80], 32'hE000);
    chk("R9 missed unchanged", {29'd0, missed_cnt}, 2);

    @(negedge clk); missed_rd = 1'b1;
    @(negedge clk); missed_rd = 1'b0;
    chk("R13 clear on read", {29'd0, missed_cnt}, 0);
    for (int i = 0; i < 9; i++) push_frame(1, 32'h9000 + i);
    for (int k = 0; k < 5000 && fwp != frp; k++) @(negedge clk);
    settle(30);
    chk("R13 saturation", {29'd0, missed_cnt}, 7);
    chk("R10 all stored frames dropped", fwp - frp, 0);
    @(negedge clk); missed_rd = 1'b1;
    @(negedge clk); missed_rd = 1'b0;
    chk("R13 clear after saturation", {29'd0, missed_cnt}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule